// File: doc/BRIEF.md
# Accumulator Processor Datapath

This block holds every register and every arithmetic path of a small 8-bit accumulator machine: an instruction register, a 5-bit program counter, an 8-bit accumulator and a 32-word by 8-bit register-file memory. The memory starts out holding a GCD program that works by repeated subtraction. A separate sequencer drives the control inputs one cycle at a time. It reads back the opcode field of the instruction register and two accumulator flags, one for zero and one for non-negative. From these it decides what the datapath does in the next cycle.

Every instruction is one byte. The upper three bits are the opcode and the lower five bits are a memory address. The instruction fetch and the data accesses use the same memory. The program counter and the address field of the instruction register both address it, through one address mux. The accumulator is loaded from one of three sources: the adder-subtractor result, an external byte input, or the memory read data. It is also the only value that can be written into memory.

Top module: `acc_datapath`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the instruction register, the program counter and the accumulator are all cleared. Memory contents are not affected by reset.
- R2: With `ir_load` high, the instruction register captures the currently addressed memory word at the rising edge. With `ir_load` low, it keeps its value. `opcode` shows bits 7:5 of the instruction register.
- R3: With `addr_from_ir` high, the memory address is bits 4:0 of the instruction register. With it low, the memory address is the program counter.
- R4: With `pc_load` high and `jmp_sel` low, the program counter steps by one, wrapping from 31 to 0. With `pc_load` and `jmp_sel` both high, it takes bits 4:0 of the instruction register. With `pc_load` low, it holds.
- R5: With `a_load` high, the accumulator takes the value selected by `a_src`: 2'b00 the adder-subtractor result, 2'b01 `ext_in`, 2'b10 the memory read data.
- R6: The adder-subtractor works modulo 256. With `sub_en` low it produces accumulator + memory word. With `sub_en` high it produces accumulator − memory word, computed as the accumulator plus the two's complement of the word.
- R7: With `mem_wr` high, the accumulator value is written into the addressed word at the rising edge. Reads of the memory are combinational.
- R8: `a_zero` is high exactly when all accumulator bits are 0. `a_pos` is high exactly when accumulator bit 7 is 0. `acc_out` is the accumulator.
- R9: After power-up, words 0 to 17 hold the GCD program and words 18 to 31 hold 0. The opcodes are LOAD=000, STORE=001, ADD=010, SUB=011, IN=100, JZ=101, JPOS=110 and HALT=111. The program words are 80 3E 80 3F 1E 7F B0 CC 1F 7E 3F C4 3E C4 1E FF 1E FF (hex). Operands are kept at words 30 and 31, and the GCD sits in the accumulator when HALT is reached.
- R10: With `a_load` low, or with `a_src` = 2'b11, the accumulator keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ir_load | input | 1 | Capture addressed memory word into instruction register |
| jmp_sel | input | 1 | Program counter source: 1 = IR address field, 0 = PC+1 |
| pc_load | input | 1 | Update program counter |
| addr_from_ir | input | 1 | Memory address source: 1 = IR address field, 0 = PC |
| mem_wr | input | 1 | Write accumulator into addressed word |
| a_src | input | 2 | Accumulator source code |
| a_load | input | 1 | Update accumulator |
| sub_en | input | 1 | Adder-subtractor subtracts when high |
| ext_in | input | 8 | External data byte |
| opcode | output | 3 | Instruction register bits 7:5 |
| a_zero | output | 1 | Accumulator equals zero |
| a_pos | output | 1 | Accumulator sign bit clear |
| acc_out | output | 8 | Accumulator value |

## Verification
The main function, running the stored GCD program, is driven by a small sequencer model in the bench. It uses operand pairs that are multiples of each other, coprime pairs, pairs where the first operand is smaller, and equal operands. Together these exercise both swap branches and the immediate-zero exit. The adder-subtractor is tried with a sum that overflows, a subtraction that goes negative, and a subtraction of equal values. These separate modular wrap, sign flag and zero flag. Program counter stepping past word 31, jumps, and the two address sources are observed by loading memory words into the accumulator. Each such word is placed at an address only one path can reach.

// File: rtl/acc_dp_pkg.sv
// Package: shared codes and the preloaded program image of the accumulator datapath.
// Assumes the default 8-bit word with a 3-bit opcode over a 5-bit address field.
package acc_dp_pkg;

    localparam int WORD_W = 8;
    localparam int ADR_W  = 5;
    localparam int OPC_W  = WORD_W - ADR_W;
    localparam int PROG_LEN = 18;

    typedef enum logic [1:0] {
        SRC_SUM  = 2'b00,
        SRC_EXT  = 2'b01,
        SRC_MEM  = 2'b10,
        SRC_HOLD = 2'b11
    } acc_src_e;

    typedef enum logic [OPC_W-1:0] {
        OPC_LOAD  = 3'd0,
        OPC_STORE = 3'd1,
        OPC_ADD   = 3'd2,
        OPC_SUB   = 3'd3,
        OPC_IN    = 3'd4,
        OPC_JZ    = 3'd5,
        OPC_JPOS  = 3'd6,
        OPC_HALT  = 3'd7
    } opc_e;

    localparam logic [ADR_W-1:0] OPND_X = 5'd30;
    localparam logic [ADR_W-1:0] OPND_Y = 5'd31;

    // Pack one instruction word.
    function automatic logic [WORD_W-1:0] mk_instr(opc_e op, logic [ADR_W-1:0] adr);
        return {op, adr};
    endfunction

    // Program image: repeated-subtraction GCD over words 30 and 31.
    function automatic logic [WORD_W-1:0] prog_word(int idx);
        case (idx)
            0:  return mk_instr(OPC_IN,    5'd0);
            1:  return mk_instr(OPC_STORE, OPND_X);
            2:  return mk_instr(OPC_IN,    5'd0);
            3:  return mk_instr(OPC_STORE, OPND_Y);
            4:  return mk_instr(OPC_LOAD,  OPND_X);
            5:  return mk_instr(OPC_SUB,   OPND_Y);
            6:  return mk_instr(OPC_JZ,    5'd16);
            7:  return mk_instr(OPC_JPOS,  5'd12);
            8:  return mk_instr(OPC_LOAD,  OPND_Y);
            9:  return mk_instr(OPC_SUB,   OPND_X);
            10: return mk_instr(OPC_STORE, OPND_Y);
            11: return mk_instr(OPC_JPOS,  5'd4);
            12: return mk_instr(OPC_STORE, OPND_X);
            13: return mk_instr(OPC_JPOS,  5'd4);
            14: return mk_instr(OPC_LOAD,  OPND_X);
            15: return mk_instr(OPC_HALT,  5'd31);
            16: return mk_instr(OPC_LOAD,  OPND_X);
            17: return mk_instr(OPC_HALT,  5'd31);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/acc_dp_reg.sv
// Module: load-enabled register with synchronous active-low clear.
// Assumes the caller gates updates through ld; value is held otherwise.
module acc_dp_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Clear on reset, capture d when ld is set.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
    end

endmodule

// File: rtl/acc_dp_mem.sv
// Module: register-file memory, combinational read, synchronous write.
// Assumes the program image from the package; reset does not touch the contents.
module acc_dp_mem
    import acc_dp_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int AW = ADR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    // Power-up image.
    initial begin
        for (int i = 0; i < DEPTH; i++) mem_q[i] = DW'(prog_word(i));
    end

    // Write port.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[addr] <= wr_data;
    end

    // Read port.
    assign rd_data = mem_q[addr];

    // R7
    wr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (addr != $past(addr)) || (rd_data == $past(wr_data)));

endmodule

// File: rtl/acc_dp_addsub.sv
// Module: adder-subtractor, result modulo 2**W.
// Assumes subtraction by adding the inverted operand plus a carry-in of one.
module acc_dp_addsub #(
    parameter int W = 8
) (
    input  logic         sub,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] res
);

    logic [W-1:0] rhs_eff;

    // Operand conditioning: invert per bit for subtraction.
    for (genvar b = 0; b < W; b++) begin : g_inv
        assign rhs_eff[b] = rhs[b] ^ sub;
    end

    // Single adder with carry-in.
    always_comb begin
        res = lhs + rhs_eff + W'(sub);
    end

endmodule

// File: rtl/acc_datapath.sv
// Module: accumulator machine datapath (IR, PC, accumulator, memory, ALU, muxes).
// Assumes an external sequencer drives one set of controls per cycle and reads
// opcode, a_zero and a_pos between edges.
module acc_datapath
    import acc_dp_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int AW = ADR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ir_load,
    input  logic          jmp_sel,
    input  logic          pc_load,
    input  logic          addr_from_ir,
    input  logic          mem_wr,
    input  logic [1:0]    a_src,
    input  logic          a_load,
    input  logic          sub_en,
    input  logic [DW-1:0] ext_in,
    output logic [DW-AW-1:0] opcode,
    output logic          a_zero,
    output logic          a_pos,
    output logic [DW-1:0] acc_out
);

    localparam int OW = DW - AW;

    logic [DW-1:0] ir_q, acc_q, acc_d, ram_rd, alu_res;
    logic [AW-1:0] pc_q, pc_d, mem_addr, ir_adr;

    assign ir_adr = ir_q[AW-1:0];

    // Address source select.
    assign mem_addr = addr_from_ir ? ir_adr : pc_q;

    // Next PC: jump target or increment.
    assign pc_d = jmp_sel ? ir_adr : AW'(pc_q + 1'b1);

    // Accumulator source select.
    always_comb begin
        case (acc_src_e'(a_src))
            SRC_SUM: acc_d = alu_res;
            SRC_EXT: acc_d = ext_in;
            SRC_MEM: acc_d = ram_rd;
            default: acc_d = acc_q;
        endcase
    end

    acc_dp_reg #(.W(DW)) u_ir (
        .clk(clk), .rst_n(rst_n), .ld(ir_load), .d(ram_rd), .q(ir_q));

    acc_dp_reg #(.W(AW)) u_pc (
        .clk(clk), .rst_n(rst_n), .ld(pc_load), .d(pc_d), .q(pc_q));

    acc_dp_reg #(.W(DW)) u_acc (
        .clk(clk), .rst_n(rst_n), .ld(a_load), .d(acc_d), .q(acc_q));

    acc_dp_mem #(.DW(DW), .AW(AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(mem_wr), .addr(mem_addr),
        .wr_data(acc_q), .rd_data(ram_rd));

    acc_dp_addsub #(.W(DW)) u_alu (
        .sub(sub_en), .lhs(acc_q), .rhs(ram_rd), .res(alu_res));

    // Status and data outputs.
    assign opcode  = ir_q[DW-1 -: OW];
    assign a_zero  = ~|acc_q;
    assign a_pos   = ~acc_q[DW-1];
    assign acc_out = acc_q;

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pc_q == '0) && (acc_q == '0) && (ir_q == '0));

    // R2
    ir_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load |=> ir_q == $past(ram_rd));

    // R2
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_load |=> $stable(ir_q));

    // R4
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && !jmp_sel) |=> pc_q == AW'($past(pc_q) + 1));

    // R4
    pc_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && jmp_sel) |=> pc_q == $past(ir_q[AW-1:0]));

    // R4
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_load |=> $stable(pc_q));

    // R5
    acc_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_load && a_src == SRC_EXT) |=> acc_q == $past(ext_in));

    // R6
    sub_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_load && a_src == SRC_SUM && sub_en && ram_rd == acc_q) |=> a_zero);

    // R10
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_load || a_src == SRC_HOLD) |=> $stable(acc_q));

endmodule

// File: tb/acc_datapath_tb_top.sv
`timescale 1ns/100ps
module acc_datapath_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ir_load = 0, jmp_sel = 0, pc_load = 0, addr_from_ir = 0, mem_wr = 0;
    logic a_load = 0, sub_en = 0;
    logic [1:0] a_src = 2'b00;
    logic [7:0] ext_in = 8'h00;
    logic [2:0] opcode;
    logic a_zero, a_pos;
    logic [7:0] acc_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    acc_datapath dut_i (
        .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .jmp_sel(jmp_sel),
        .pc_load(pc_load), .addr_from_ir(addr_from_ir), .mem_wr(mem_wr),
        .a_src(a_src), .a_load(a_load), .sub_en(sub_en), .ext_in(ext_in),
        .opcode(opcode), .a_zero(a_zero), .a_pos(a_pos), .acc_out(acc_out));

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        report();
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle_ctl();
        ir_load = 0; jmp_sel = 0; pc_load = 0; addr_from_ir = 0; mem_wr = 0;
        a_load = 0; sub_en = 0; a_src = 2'b00;
    endtask

    // One clock: controls set beforehand, results readable on return.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        idle_ctl();
    endtask

    task automatic do_reset();
        rst_n = 0; cyc(); cyc(); rst_n = 1;
    endtask

    task automatic set_acc(logic [7:0] v);
        ext_in = v; a_src = 2'b01; a_load = 1; cyc();
    endtask

    // Accumulator <- word at PC (or IR field) without other effects.
    task automatic peek(logic via_ir);
        addr_from_ir = via_ir; a_src = 2'b10; a_load = 1; cyc();
    endtask

    // Place v at word k, using word 30 as scratch; leaves IR field = k.
    task automatic write_word(logic [4:0] k, logic [7:0] v);
        do_reset();
        pc_load = 1; cyc();                      // PC = 1 (STORE 30)
        ir_load = 1; cyc();                      // IR = 0x3E
        set_acc({3'b000, k});
        addr_from_ir = 1; mem_wr = 1; cyc();     // word30 = k
        addr_from_ir = 1; ir_load = 1; cyc();    // IR field = k
        set_acc(v);
        addr_from_ir = 1; mem_wr = 1; cyc();     // word k = v
    endtask

    function automatic logic [7:0] exp_prog(int k);
        logic [7:0] img [18] = '{8'h80, 8'h3E, 8'h80, 8'h3F, 8'h1E, 8'h7F, 8'hB0, 8'hCC, 8'h1F,
                                 8'h7E, 8'h3F, 8'hC4, 8'h3E, 8'hC4, 8'h1E, 8'hFF, 8'h1E, 8'hFF};
        return (k < 18) ? img[k] : 8'h00;
    endfunction

    task automatic t_reset();
        set_acc(8'h55);
        do_reset();
        check("R1 acc after reset", acc_out, 0);
        check("R1 opcode after reset", opcode, 0);
        check("R8 zero flag at 0", a_zero, 1);
        check("R8 pos flag at 0", a_pos, 1);
        peek(0);
        check("R1 pc cleared (word0)", acc_out, 8'h80);
    endtask

    task automatic t_image();
        do_reset();
        for (int k = 0; k < 32; k++) begin
            addr_from_ir = 0; a_src = 2'b10; a_load = 1; pc_load = 1; cyc();
            check($sformatf("R9 word %0d", k), acc_out, exp_prog(k));
        end
        peek(0);
        check("R4 pc wraps 31->0", acc_out, 8'h80);
    endtask

    task automatic t_gcd(int x, int y);
        int g = x, h = y, t, ins = 0, ins_cnt = 0;
        logic halted = 0;
        while (h != 0) begin t = g % h; g = h; h = t; end
        do_reset();
        while (!halted && ins < 2000) begin
            ir_load = 1; pc_load = 1; cyc();
            ins++;
            case (opcode)
                3'd0: begin addr_from_ir = 1; a_src = 2'b10; a_load = 1; cyc(); end
                3'd1: begin addr_from_ir = 1; mem_wr = 1; cyc(); end
                3'd2: begin addr_from_ir = 1; a_src = 2'b00; a_load = 1; cyc(); end
                3'd3: begin addr_from_ir = 1; a_src = 2'b00; sub_en = 1; a_load = 1; cyc(); end
                3'd4: begin
                    ext_in = (ins_cnt == 0) ? 8'(x) : 8'(y);
                    ins_cnt++;
                    a_src = 2'b01; a_load = 1; cyc();
                end
                3'd5: begin jmp_sel = 1; pc_load = a_zero; cyc(); end
                3'd6: begin jmp_sel = 1; pc_load = a_pos; cyc(); end
                default: halted = 1;
            endcase
        end
        check($sformatf("R9 halt reached %0d,%0d", x, y), halted, 1);
        check($sformatf("R9 gcd(%0d,%0d)", x, y), acc_out, g);
    endtask

    task automatic t_alu();
        write_word(5'd20, 8'd100);               // IR field = 20
        set_acc(8'd200);
        addr_from_ir = 1; a_src = 2'b00; a_load = 1; cyc();
        check("R6 add wraps", acc_out, 44);
        set_acc(8'd5);
        addr_from_ir = 1; a_src = 2'b00; sub_en = 1; a_load = 1; cyc();
        check("R6 sub negative", acc_out, 8'hA1);
        check("R8 pos flag low", a_pos, 0);
        check("R8 zero flag low", a_zero, 0);
        set_acc(8'd100);
        addr_from_ir = 1; a_src = 2'b00; sub_en = 1; a_load = 1; cyc();
        check("R6 sub equal", acc_out, 0);
        check("R8 zero after sub", a_zero, 1);
        peek(1);
        check("R7 written word read via IR", acc_out, 100);
        peek(0);
        check("R3 PC path reads word 1", acc_out, 8'h3E);
    endtask

    task automatic t_hold_jump();
        write_word(5'd22, 8'h6B);                // IR field = 22
        set_acc(8'h21);
        ext_in = 8'hEE; a_src = 2'b11; a_load = 1; cyc();
        check("R10 code 11 holds", acc_out, 8'h21);
        ext_in = 8'hEE; a_src = 2'b01; a_load = 0; cyc();
        check("R10 load low holds", acc_out, 8'h21);
        addr_from_ir = 1; ir_load = 0; cyc();
        check("R2 IR held with load low", opcode, 0);
        jmp_sel = 1; pc_load = 0; cyc();
        peek(0);
        check("R4 pc held without load", acc_out, 8'h3E);
        jmp_sel = 1; pc_load = 1; cyc();
        peek(0);
        check("R4 jump to IR field", acc_out, 8'h6B);
        ir_load = 1; cyc();
        check("R2 IR captures word at PC", opcode, 3);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_image();
        t_gcd(10, 5);
        t_gcd(10, 9);
        t_gcd(8, 12);
        t_gcd(21, 21);
        t_gcd(127, 1);
        t_alu();
        t_hold_jump();
        report();
    end

endmodule